// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is the target side of a two-wire serial memory that holds 256 bytes in an internal register array. The clock and data lines arrive asynchronously. They are resynchronised to the system clock and watched for clock edges and for the bus conditions that begin and end a transfer. The first byte of every transfer names the device. The block answers only when that byte carries the fixed device code and the three chip-select straps. After that it runs a single-byte write, a page write, or a read that starts at a word address or at the current pointer.

Written bytes collect in a page-sized buffer, and the low address bits select the slot for each byte. Nothing reaches the array until a stop condition closes the write. At that point a timed internal write cycle starts, and the buffered bytes are committed to the array when the cycle ends. While the cycle runs, the block stays silent on the bus. A host can therefore poll with the device byte and see the first acknowledge as the sign that the write has completed. The block drives the data line only by pulling it low, through an enable output that feeds an open-drain pad.

Top module: `twi_eeprom_target`

## Requirements
- R1: After reset the pull-down output is inactive and every array location reads back as 0xFF.
- R2: A device byte is accepted only when bits 7..4 equal 1010 and bits 3..1 equal `chip_sel_i`. Any other device byte gets no acknowledge, and the block ignores the rest of the transfer, including later bytes, until the next start condition.
- R3: For each accepted byte the block pulls SDA low through the ninth SCL clock, and it never pulls SDA during the eight data bits that the host sends.
- R4: Bit 0 of the device byte selects the direction (0 = write, 1 = read). A write carries one word-address byte and then data. A stop after one data byte stores that byte at the word address.
- R5: Further data bytes in a write go to successive slots of the same 8-byte page. Only address bits 2..0 advance. A ninth or later byte wraps to the page start and overwrites the earlier byte, and neighbouring pages are untouched.
- R6: The write cycle starts only when a stop condition ends a write transfer that carried data, and it lasts `WR_CYCLES` system clocks. During the cycle the device byte gets no acknowledge. A repeated start before any stop commits nothing.
- R7: A falling SDA while SCL is high is a start condition and a rising SDA while SCL is high is a stop condition. Either one aborts the byte in progress. A start condition restarts device-byte decoding.
- R8: A read returns the byte at the address pointer, most significant bit first. The pointer advances by one after each byte, wrapping from 0xFF to 0x00, for as long as the host acknowledges. A host non-acknowledge releases the bus. A read without a word address starts at the current pointer.
- R9: While `wp_i` is high at the stop condition, write bytes are still acknowledged, but nothing is stored and no write cycle starts, so the next device byte is acknowledged at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| chip_sel_i | input | 3 | Strapped chip-select value compared with device byte bits 3..1 |
| wp_i | input | 1 | Write protect; high blocks array updates |
| sda_pull_o | output | 1 | High pulls SDA low (open-drain enable) |

## Verification
A ten-byte page write that starts mid-page checks the slot wraparound. A design that carried into the upper address bits would corrupt the next page, and one that stopped at eight bytes would leave the first two slots with stale data. Polling right after a stop checks for silence during the write cycle, since a design that acknowledged while busy would let the host read an unfinished location. A repeated start placed after a data byte checks that an early commit shows up as changed data. A write-protected write checks both that the bytes are acknowledged and that the block does not fall silent, which a design that started a cycle anyway would do. Reads that cross 0xFF into 0x00, mismatched device bytes followed by more data, and a current-address read cover the pointer and decode edges.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;

    localparam int BYTE_W = 8;
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_WADDR,
        ST_WDATA,
        ST_RSTART,
        ST_RDATA
    } proto_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } line_ev_t;

    function automatic logic dev_hit(input logic [BYTE_W-1:0] b, input logic [2:0] sel);
        return (b[7:4] == DEV_CODE) && (b[3:1] == sel);
    endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync
    import twi_eeprom_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev_o
);
    localparam int DEPTH = 3;

    logic [DEPTH-1:0] scl_q;
    logic [DEPTH-1:0] sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= {scl_q[DEPTH-2:0], scl_i};
            sda_q <= {sda_q[DEPTH-2:0], sda_i};
        end
    end

    // bit 1 is the settled sample, bit 2 the one before it
    always_comb begin
        ev_o.scl_rise = scl_q[1] & ~scl_q[2];
        ev_o.scl_fall = ~scl_q[1] & scl_q[2];
        ev_o.start    = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
        ev_o.stop     = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
        ev_o.sda      = sda_q[1];
    end
endmodule

// File: rtl/twi_array_store.sv
module twi_array_store
    import twi_eeprom_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int PAGE_W    = 3,
    parameter int WR_CYCLES = 64
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              commit_i,
    input  logic [ADDR_W-PAGE_W-1:0]          commit_base_i,
    input  logic [(1<<PAGE_W)-1:0][BYTE_W-1:0] commit_data_i,
    input  logic [(1<<PAGE_W)-1:0]            commit_mask_i,
    input  logic [ADDR_W-1:0]                 rd_addr_i,
    output logic [BYTE_W-1:0]                 rd_data_o,
    output logic                              busy_o
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int PAGE_N = 1 << PAGE_W;
    localparam int BASE_W = ADDR_W - PAGE_W;
    localparam int CNT_W  = $clog2(WR_CYCLES + 1);

    logic [BYTE_W-1:0]             mem [DEPTH];
    logic [CNT_W-1:0]              tmr;
    logic [BASE_W-1:0]             lat_base;
    logic [PAGE_N-1:0][BYTE_W-1:0] lat_data;
    logic [PAGE_N-1:0]             lat_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
            tmr      <= '0;
            busy_o   <= 1'b0;
            lat_base <= '0;
            lat_data <= '0;
            lat_mask <= '0;
        end else if (busy_o) begin
            if (tmr == '0) begin
                busy_o <= 1'b0;
                for (int j = 0; j < PAGE_N; j++) begin
                    if (lat_mask[j]) mem[{lat_base, PAGE_W'(j)}] <= lat_data[j];
                end
            end else begin
                tmr <= tmr - 1'b1;
            end
        end else if (commit_i) begin
            busy_o   <= 1'b1;
            tmr      <= CNT_W'(WR_CYCLES - 1);
            lat_base <= commit_base_i;
            lat_data <= commit_data_i;
            lat_mask <= commit_mask_i;
        end
    end

    assign rd_data_o = mem[rd_addr_i];

    // R6: the protocol side never asks for a commit while a cycle runs
    assert_commit_idle_R6: assert property (@(posedge clk) disable iff (rst)
        commit_i |-> !busy_o);
    // R6: a commit request always opens a write cycle
    assert_commit_starts_R6: assert property (@(posedge clk) disable iff (rst)
        commit_i |=> busy_o);
endmodule

// File: rtl/twi_proto_engine.sv
module twi_proto_engine
    import twi_eeprom_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 3
) (
    input  logic                              clk,
    input  logic                              rst,
    input  line_ev_t                          ev_i,
    input  logic [2:0]                        chip_sel_i,
    input  logic                              wp_i,
    input  logic                              busy_i,
    input  logic [BYTE_W-1:0]                 rd_data_i,
    output logic [ADDR_W-1:0]                 rd_addr_o,
    output logic                              commit_o,
    output logic [ADDR_W-PAGE_W-1:0]          commit_base_o,
    output logic [(1<<PAGE_W)-1:0][BYTE_W-1:0] commit_data_o,
    output logic [(1<<PAGE_W)-1:0]            commit_mask_o,
    output logic                              sda_pull_o
);
    localparam int PAGE_N = 1 << PAGE_W;

    proto_state_e                  state;
    logic [3:0]                    cnt;
    logic [BYTE_W-1:0]             shreg;
    logic [BYTE_W-1:0]             txreg;
    logic [ADDR_W-1:0]             ptr;
    logic [PAGE_N-1:0][BYTE_W-1:0] pbuf;
    logic [PAGE_N-1:0]             pvalid;
    logic [PAGE_W-1:0]             slot;

    assign slot = ptr[PAGE_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            shreg      <= '0;
            txreg      <= '0;
            ptr        <= '0;
            pbuf       <= '0;
            pvalid     <= '0;
            commit_o   <= 1'b0;
            sda_pull_o <= 1'b0;
        end else begin
            commit_o <= 1'b0;
            if (ev_i.start) begin
                state      <= ST_DEV;
                cnt        <= '0;
                pvalid     <= '0;
                sda_pull_o <= 1'b0;
            end else if (ev_i.stop) begin
                if (state == ST_WDATA && |pvalid && !wp_i) commit_o <= 1'b1;
                state      <= ST_IDLE;
                cnt        <= '0;
                sda_pull_o <= 1'b0;
            end else if (state == ST_RDATA) begin
                if (ev_i.scl_rise) begin
                    if (cnt < 4'd8) begin
                        cnt <= cnt + 4'd1;
                    end else if (cnt == 4'd8) begin
                        cnt <= 4'd9;
                        if (ev_i.sda) state <= ST_IDLE;   // host declined more
                    end
                end else if (ev_i.scl_fall) begin
                    if (cnt == 4'd8) begin
                        sda_pull_o <= 1'b0;
                        ptr        <= ptr + 1'b1;
                    end else if (cnt == 4'd9) begin
                        txreg      <= rd_data_i;
                        sda_pull_o <= ~rd_data_i[7];
                        cnt        <= '0;
                    end else if (cnt != 4'd0) begin
                        txreg      <= {txreg[6:0], 1'b0};
                        sda_pull_o <= ~txreg[6];
                    end
                end
            end else if (state != ST_IDLE) begin
                if (ev_i.scl_rise) begin
                    if (cnt < 4'd8) begin
                        shreg <= {shreg[6:0], ev_i.sda};
                        cnt   <= cnt + 4'd1;
                    end else if (cnt == 4'd8) begin
                        cnt <= 4'd9;
                    end
                end else if (ev_i.scl_fall) begin
                    if (cnt == 4'd8) begin
                        case (state)
                            ST_DEV: begin
                                if (dev_hit(shreg, chip_sel_i) && !busy_i) begin
                                    sda_pull_o <= 1'b1;
                                    state      <= shreg[0] ? ST_RSTART : ST_WADDR;
                                end else begin
                                    state <= ST_IDLE;
                                    cnt   <= '0;
                                end
                            end
                            ST_WADDR: begin
                                ptr        <= ADDR_W'(shreg);
                                pvalid     <= '0;
                                sda_pull_o <= 1'b1;
                                state      <= ST_WDATA;
                            end
                            ST_WDATA: begin
                                pbuf[slot]         <= shreg;
                                pvalid[slot]       <= 1'b1;
                                ptr[PAGE_W-1:0]    <= slot + 1'b1;
                                sda_pull_o         <= 1'b1;
                            end
                            default: ;
                        endcase
                    end else if (cnt == 4'd9) begin
                        cnt <= '0;
                        if (state == ST_RSTART) begin
                            txreg      <= rd_data_i;
                            sda_pull_o <= ~rd_data_i[7];
                            state      <= ST_RDATA;
                        end else begin
                            sda_pull_o <= 1'b0;
                        end
                    end
                end
            end
        end
    end

    assign rd_addr_o     = ptr;
    assign commit_base_o = ptr[ADDR_W-1:PAGE_W];
    assign commit_data_o = pbuf;
    assign commit_mask_o = pvalid;

    // R3: outside a read, the line is pulled only in the acknowledge slot
    assert_ack_slot_R3: assert property (@(posedge clk) disable iff (rst)
        (state != ST_RDATA && sda_pull_o) |-> (cnt == 4'd8 || cnt == 4'd9));
    // R2: a foreign device byte leaves the block idle and silent
    assert_foreign_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DEV && ev_i.scl_fall && !ev_i.start && !ev_i.stop && cnt == 4'd8
         && !dev_hit(shreg, chip_sel_i)) |=> (state == ST_IDLE && !sda_pull_o));
    // R5: page bits of the pointer hold while data bytes stream in
    assert_page_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WDATA && $past(state == ST_WDATA))
        |-> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])));
    // R6: no acknowledge to a device byte during the write cycle
    assert_busy_silent_R6: assert property (@(posedge clk) disable iff (rst)
        (busy_i && state == ST_DEV) |-> !sda_pull_o);
    // R7: a start condition restarts decoding with the line released
    assert_start_clears_R7: assert property (@(posedge clk) disable iff (rst)
        ev_i.start |=> (state == ST_DEV && cnt == 4'd0 && !sda_pull_o));
    // R9: a protected stop never commits
    assert_wp_blocks_R9: assert property (@(posedge clk) disable iff (rst)
        commit_o |-> !$past(wp_i));
endmodule

// File: rtl/twi_eeprom_target.sv
module twi_eeprom_target
    import twi_eeprom_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int PAGE_W    = 3,
    parameter int WR_CYCLES = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] chip_sel_i,
    input  logic       wp_i,
    output logic       sda_pull_o
);
    localparam int PAGE_N = 1 << PAGE_W;

    line_ev_t                      ev;
    logic                          commit;
    logic [ADDR_W-PAGE_W-1:0]      commit_base;
    logic [PAGE_N-1:0][BYTE_W-1:0] commit_data;
    logic [PAGE_N-1:0]             commit_mask;
    logic [ADDR_W-1:0]             rd_addr;
    logic [BYTE_W-1:0]             rd_data;
    logic                          busy;

    twi_line_sync u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    twi_proto_engine #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_engine (
        .clk           (clk),
        .rst           (rst),
        .ev_i          (ev),
        .chip_sel_i    (chip_sel_i),
        .wp_i          (wp_i),
        .busy_i        (busy),
        .rd_data_i     (rd_data),
        .rd_addr_o     (rd_addr),
        .commit_o      (commit),
        .commit_base_o (commit_base),
        .commit_data_o (commit_data),
        .commit_mask_o (commit_mask),
        .sda_pull_o    (sda_pull_o)
    );

    twi_array_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_store (
        .clk           (clk),
        .rst           (rst),
        .commit_i      (commit),
        .commit_base_i (commit_base),
        .commit_data_i (commit_data),
        .commit_mask_i (commit_mask),
        .rd_addr_i     (rd_addr),
        .rd_data_o     (rd_data),
        .busy_o        (busy)
    );
endmodule

// File: tb/twi_eeprom_target_tb.sv
`timescale 1ns/1ps
module twi_eeprom_target_tb;
    localparam int H = 10;                 // system clocks per SCL half phase
    localparam logic [2:0] SEL = 3'b101;

    logic clk = 1'b0;
    always #10 clk = ~clk;                 // 50 MHz

    logic rst, host_scl, host_sda, wp;
    logic sda_pull, sda_bus;
    assign sda_bus = host_sda & ~sda_pull;

    twi_eeprom_target #(.WR_CYCLES(600)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (host_scl),
        .sda_i      (sda_bus),
        .chip_sel_i (SEL),
        .wp_i       (wp),
        .sda_pull_o (sda_pull)
    );

    int total = 0, bad = 0, stray = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] got_q[$];
    logic [7:0] wq[$];
    logic [7:0] eq[$];
    bit done = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] dev(input bit rd);
        return {4'b1010, SEL, rd};
    endfunction

    task automatic bus_start();
        host_sda = 1'b1; clks(H);
        host_scl = 1'b1; clks(H);
        host_sda = 1'b0; clks(H);
        host_scl = 1'b0; clks(H);
    endtask

    task automatic bus_stop();
        host_sda = 1'b0; clks(H);
        host_scl = 1'b1; clks(H);
        host_sda = 1'b1; clks(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            host_sda = b[i]; clks(H);
            host_scl = 1'b1; clks(H/2);
            if (b[i] && !sda_bus) stray++;
            clks(H - H/2);
            host_scl = 1'b0; clks(H);
        end
        host_sda = 1'b1; clks(H);
        host_scl = 1'b1; clks(H/2);
        acked = !sda_bus;
        clks(H - H/2);
        host_scl = 1'b0; clks(H);
    endtask

    task automatic recv_byte(input bit host_ack);
        logic [7:0] b;
        b = '0;
        for (int i = 7; i >= 0; i--) begin
            host_sda = 1'b1; clks(H);
            host_scl = 1'b1; clks(H/2);
            b[i] = sda_bus;
            clks(H - H/2);
            host_scl = 1'b0;
        end
        clks(H);
        host_sda = host_ack ? 1'b0 : 1'b1; clks(H);
        host_scl = 1'b1; clks(H);
        host_scl = 1'b0; clks(H);
        host_sda = 1'b1;
        got_q.push_back(b);
    endtask

    // write device byte, word address and the bytes in wq, then stop
    task automatic write_seq(input logic [7:0] addr, input string req);
        bit a;
        bus_start();
        send_byte(dev(1'b0), a); check(a, req, "ack device byte (write)", a, 1);
        send_byte(addr, a);      check(a, req, "ack word address", a, 1);
        foreach (wq[k]) begin
            send_byte(wq[k], a); check(a, "R3", "ack data byte", a, 1);
        end
        bus_stop();
    endtask

    // random read of eq.size() bytes from addr, expectations pushed to the scoreboard
    task automatic read_seq(input logic [7:0] addr, input string req);
        bit a;
        foreach (eq[k]) begin exp_q.push_back(eq[k]); tag_q.push_back(req); end
        bus_start();
        send_byte(dev(1'b0), a); check(a, "R4", "ack device byte before read", a, 1);
        send_byte(addr, a);      check(a, "R4", "ack read address", a, 1);
        bus_start();
        send_byte(dev(1'b1), a); check(a, "R7", "ack after repeated start", a, 1);
        for (int k = 0; k < eq.size(); k++) recv_byte(k != eq.size() - 1);
        bus_stop();
    endtask

    task automatic wait_ready(output int polls);
        bit a;
        polls = 0;
        for (int k = 0; k < 60; k++) begin
            bus_start();
            send_byte(dev(1'b0), a);
            bus_stop();
            if (a) break;
            polls++;
        end
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(posedge clk);
            while (got_q.size() > 0) begin
                logic [7:0] g, e;
                string t;
                g = got_q.pop_front();
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8", "unexpected read byte", g, 0);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(g == e, t, "read data", g, e);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit a;
        int polls;
        rst = 1'b1; host_scl = 1'b1; host_sda = 1'b1; wp = 1'b0;
        clks(5);
        rst = 1'b0;
        clks(5);
        check(sda_pull == 1'b0, "R1", "pull idle after reset", sda_pull, 0);

        eq.delete(); eq.push_back(8'hFF);
        read_seq(8'h00, "R1");

        // R4 byte write, then R6 polling during the cycle
        wq.delete(); wq.push_back(8'h5A);
        write_seq(8'h25, "R4");
        bus_start();
        send_byte(dev(1'b0), a);
        bus_stop();
        check(!a, "R6", "no ack while write cycle runs", a, 0);
        wait_ready(polls);
        check(polls < 60, "R6", "write cycle finishes", polls, 0);
        eq.delete(); eq.push_back(8'h5A);
        read_seq(8'h25, "R4");

        // R2 foreign device bytes
        bus_start();
        send_byte({4'b1010, 3'b011, 1'b0}, a);
        check(!a, "R2", "chip select mismatch not acked", a, 0);
        send_byte(8'h10, a);
        check(!a, "R2", "byte after mismatch ignored", a, 0);
        bus_stop();
        bus_start();
        send_byte({4'b1011, SEL, 1'b0}, a);
        check(!a, "R2", "device code mismatch not acked", a, 0);
        bus_stop();

        // R5 page write of ten bytes starting at slot 3 of page 0x40
        wq.delete();
        for (int k = 0; k < 10; k++) wq.push_back(8'h10 + 8'(k));
        write_seq(8'h43, "R5");
        wait_ready(polls);
        eq.delete();
        eq.push_back(8'h15); eq.push_back(8'h16); eq.push_back(8'h17);
        eq.push_back(8'h18); eq.push_back(8'h19); eq.push_back(8'h12);
        eq.push_back(8'h13); eq.push_back(8'h14); eq.push_back(8'hFF);
        read_seq(8'h40, "R5");

        // R6/R7 repeated start after a data byte commits nothing
        bus_start();
        send_byte(dev(1'b0), a);
        send_byte(8'h80, a);
        send_byte(8'hA5, a);
        check(a, "R3", "ack data before repeated start", a, 1);
        eq.delete(); eq.push_back(8'hFF);
        read_seq(8'h80, "R6");
        bus_start();
        send_byte(dev(1'b0), a);
        bus_stop();
        check(a, "R6", "no write cycle without stop after data", a, 1);

        // R7 stop right after the word address: no cycle, no data
        bus_start();
        send_byte(dev(1'b0), a);
        send_byte(8'h50, a);
        bus_stop();
        bus_start();
        send_byte(dev(1'b0), a);
        bus_stop();
        check(a, "R7", "stop without data leaves block ready", a, 1);

        // R9 write protect
        wp = 1'b1;
        wq.delete(); wq.push_back(8'h77);
        write_seq(8'h30, "R9");
        bus_start();
        send_byte(dev(1'b0), a);
        bus_stop();
        check(a, "R9", "protected write starts no cycle", a, 1);
        wp = 1'b0;
        eq.delete(); eq.push_back(8'hFF);
        read_seq(8'h30, "R9");

        // R8 pointer wrap and current-address read
        wq.delete(); wq.push_back(8'h99);
        write_seq(8'h01, "R4");
        wait_ready(polls);
        wq.delete(); wq.push_back(8'h3C);
        write_seq(8'hFF, "R4");
        wait_ready(polls);
        eq.delete(); eq.push_back(8'h3C); eq.push_back(8'hFF);
        read_seq(8'hFF, "R8");
        exp_q.push_back(8'h99); tag_q.push_back("R8");
        bus_start();
        send_byte(dev(1'b1), a);
        check(a, "R8", "ack current-address read", a, 1);
        recv_byte(1'b0);
        bus_stop();
        check(sda_pull == 1'b0, "R8", "line released after host nack", sda_pull, 0);

        clks(20);
        check(exp_q.size() == 0, "R8", "all expected reads seen", exp_q.size(), 0);
        check(stray == 0, "R3", "no pull during host data bits", stray, 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule